// File: doc/BRIEF.md
# Pattern fetch bank resolver

This block sits between a video processor's pattern fetches and a banked pattern memory. Each fetch presents a 13-bit address and a phase flag (background or sprite). The block maps the fetch onto a linear memory address using a bank-size mode and one of two sets of bank registers. Set A has eight registers and set B has four. Two overrides can replace the normal mapping for background fetches: a per-tile bank taken from an extended attribute, and a split-region bank with its own fine vertical scroll.

Software loads the bank, mode, upper-bank and split registers through a single write port. The video side pulses a load strobe whenever a fresh per-tile bank is available. Each resolved address appears one clock after its fetch request and stays on the output until the next request.

Top module: `chr_bank_resolver`

## Requirements
- R1: After reset every bank register holds 0x3FF, set A counts as the most recently written set, the mode is 3, the upper-bank value and split registers are 0, both override-valid flags are clear, and `out_valid` and `out_addr` are 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `fetch_req` high, and `out_addr` carries the resolved address of that request. It keeps its value while no request arrives.
- R3: Write select codes: 0..7 are set A registers 0..7, 8..11 are set B registers 0..3, 12 is mode (data[1:0]), 13 is upper-bank (data[1:0]), 14 is split bank (8 bits) and 15 is split fine scroll (data[2:0]). A bank register stores the upper-bank value in bits [9:8] and the written byte in bits [7:0].
- R4: The mode sets the page size: 3 gives 1 KiB, 2 gives 2 KiB, 1 gives 4 KiB and 0 gives 8 KiB. With slot = fetch_addr[12:10], a set A lookup reads register slot (mode 3), slot|1 (mode 2), slot|3 (mode 1) or 7 (mode 0). The result is page × page size + in-page offset.
- R5: A set B lookup reads register 8 + (set A index & 3), so both 4 KiB halves share the four registers. In mode 0 the in-page offset is fetch_addr[11:0].
- R6: With `tall_sprites` high, sprite fetches (`fetch_sprite`=1) use set A and background fetches use set B.
- R7: With `tall_sprites` low, every fetch uses the set that took the latest bank-register write.
- R8: `ext_load` latches the bank {upper-bank, ext_tile_bank[5:0]} and marks it valid. While `ext_attr_en` is high and the bank is valid, a background fetch resolves to bank × 4096 + fetch_addr[11:0].
- R9: While `split_active` is high and the split bank is valid, a background fetch resolves to split_bank × 4096 + (fetch_addr & 0x3F8) + fine_scroll.
- R10: A write to the mode register, the upper-bank register or any bank register clears both valid flags, even when `ext_load` arrives in the same cycle. A split bank write sets the split-valid flag.
- R11: The extended override wins over the split override, which wins over the normal lookup. Sprite fetches are never overridden.
- R12: A fetch in the same cycle as a register write resolves with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 8 | Register write data |
| ext_load | input | 1 | Latch a new per-tile bank |
| ext_tile_bank | input | 6 | Low six bits of the per-tile attribute byte |
| ext_attr_en | input | 1 | Extended-attribute mode enable |
| split_active | input | 1 | Current tile lies inside the split region |
| tall_sprites | input | 1 | 8x16 sprite size in effect |
| fetch_req | input | 1 | Pattern fetch request |
| fetch_sprite | input | 1 | 1 for sprite phase, 0 for background |
| fetch_addr | input | 13 | Pattern-table fetch address |
| out_valid | output | 1 | Resolved address is present |
| out_addr | output | 23 | Resolved linear pattern-memory address |

## Verification
Most wrong internal states show up as a wrong linear address one clock after the next fetch that reads the bad state. A stale valid flag shows on the first background fetch with the matching override enabled. A wrong last-written-set marker shows on the first fetch with 8x16 sprites off. A register that took its upper bits from the wrong moment shows only through its own slot and mode, so the fetch patterns walk every slot in every mode and in both sets.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  typedef enum logic [1:0] {PG_8K = 2'd0, PG_4K = 2'd1, PG_2K = 2'd2, PG_1K = 2'd3} page_mode_t;

  localparam logic [3:0] SEL_MODE   = 4'd12;
  localparam logic [3:0] SEL_UPPER  = 4'd13;
  localparam logic [3:0] SEL_SPLIT  = 4'd14;
  localparam logic [3:0] SEL_FINE   = 4'd15;

  // set A register index for a 1 KiB slot under a page mode
  function automatic logic [2:0] set_a_index(page_mode_t m, logic [2:0] slot);
    case (m)
      PG_8K:   return 3'd7;
      PG_4K:   return slot | 3'd3;
      PG_2K:   return slot | 3'd1;
      default: return slot;
    endcase
  endfunction
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 2,
  parameter int NUM_A  = 8,
  parameter int NUM_B  = 4,
  parameter int TILE_W = 6,
  parameter int FINE_W = 3,
  localparam int BANK_W = DATA_W + HI_W,
  localparam int NUM_R  = NUM_A + NUM_B,
  localparam int EXT_W  = HI_W + TILE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_load,
  input  logic [TILE_W-1:0] ext_tile_bank,
  output logic [BANK_W-1:0] bank_q [NUM_R],
  output page_mode_t        mode_q,
  output logic [HI_W-1:0]   upper_q,
  output logic [DATA_W-1:0] split_bank_q,
  output logic [FINE_W-1:0] split_fine_q,
  output logic              last_b_q,
  output logic              ext_valid_q,
  output logic [EXT_W-1:0]  ext_bank_q,
  output logic              split_valid_q
);
  logic clr_flags;
  logic wr_bank;

  assign wr_bank   = wr_en && (wr_sel < 4'(NUM_R));
  assign clr_flags = wr_bank || (wr_en && (wr_sel == SEL_MODE || wr_sel == SEL_UPPER));

  for (genvar i = 0; i < NUM_R; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_q[i] <= '1;
      else if (wr_en && wr_sel == 4'(i))
        bank_q[i] <= {upper_q, wr_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= PG_1K;
      upper_q       <= '0;
      split_bank_q  <= '0;
      split_fine_q  <= '0;
      last_b_q      <= 1'b0;
      ext_valid_q   <= 1'b0;
      ext_bank_q    <= '0;
      split_valid_q <= 1'b0;
    end else begin
      if (wr_bank)
        last_b_q <= (wr_sel >= 4'(NUM_A));
      if (wr_en) begin
        case (wr_sel)
          SEL_MODE:  mode_q       <= page_mode_t'(wr_data[1:0]);
          SEL_UPPER: upper_q      <= wr_data[HI_W-1:0];
          SEL_SPLIT: split_bank_q <= wr_data;
          SEL_FINE:  split_fine_q <= wr_data[FINE_W-1:0];
          default: ;
        endcase
      end
      if (ext_load)
        ext_bank_q <= {upper_q, ext_tile_bank};
      if (clr_flags)
        ext_valid_q <= 1'b0;
      else if (ext_load)
        ext_valid_q <= 1'b1;
      if (clr_flags)
        split_valid_q <= 1'b0;
      else if (wr_en && wr_sel == SEL_SPLIT)
        split_valid_q <= 1'b1;
    end
  end

  // R10
  flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel <= SEL_UPPER)) |=> (!ext_valid_q && !split_valid_q));

  // R10
  split_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_SPLIT) |=> split_valid_q);

  // R7
  last_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel >= 4'(NUM_A) && wr_sel < 4'(NUM_R)) |=> last_b_q);

  // R7
  last_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel < 4'(NUM_A)) |=> !last_b_q);
endmodule

// File: rtl/chr_addr_map.sv
module chr_addr_map
  import chr_bank_pkg::*;
#(
  parameter int FETCH_W = 13,
  parameter int BANK_W  = 10,
  parameter int NUM_A   = 8,
  parameter int NUM_B   = 4,
  localparam int NUM_R  = NUM_A + NUM_B,
  localparam int IDX_W  = $clog2(NUM_R),
  localparam int OUT_W  = BANK_W + FETCH_W
) (
  input  page_mode_t         mode,
  input  logic               use_b,
  input  logic [FETCH_W-1:0] addr,
  input  logic [BANK_W-1:0]  bank [NUM_R],
  output logic [OUT_W-1:0]   lin_addr
);
  logic [2:0]        idx_a;
  logic [IDX_W-1:0]  idx;
  logic [BANK_W-1:0] page;

  always_comb begin
    idx_a = set_a_index(mode, addr[FETCH_W-1 -: 3]);
    idx   = use_b ? IDX_W'(NUM_A) + IDX_W'(idx_a[1:0]) : IDX_W'(idx_a);
    page  = bank[idx];
    case (mode)
      PG_8K:   lin_addr = use_b ? OUT_W'({page, 1'b0, addr[FETCH_W-2:0]})
                                : OUT_W'({page, addr});
      PG_4K:   lin_addr = OUT_W'({page, addr[FETCH_W-2:0]});
      PG_2K:   lin_addr = OUT_W'({page, addr[FETCH_W-3:0]});
      default: lin_addr = OUT_W'({page, addr[FETCH_W-4:0]});
    endcase
  end
endmodule

// File: rtl/chr_bank_resolver.sv
module chr_bank_resolver
  import chr_bank_pkg::*;
#(
  parameter int FETCH_W = 13,
  parameter int DATA_W  = 8,
  parameter int HI_W    = 2,
  parameter int TILE_W  = 6,
  parameter int FINE_W  = 3,
  localparam int BANK_W = DATA_W + HI_W,
  localparam int OUT_W  = BANK_W + FETCH_W,
  localparam int NUM_A  = 8,
  localparam int NUM_B  = 4,
  localparam int NUM_R  = NUM_A + NUM_B,
  localparam int EXT_W  = HI_W + TILE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [3:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               ext_load,
  input  logic [TILE_W-1:0]  ext_tile_bank,
  input  logic               ext_attr_en,
  input  logic               split_active,
  input  logic               tall_sprites,
  input  logic               fetch_req,
  input  logic               fetch_sprite,
  input  logic [FETCH_W-1:0] fetch_addr,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_addr
);
  logic [BANK_W-1:0] bank_q [NUM_R];
  page_mode_t        mode_q;
  logic [HI_W-1:0]   upper_q;
  logic [DATA_W-1:0] split_bank_q;
  logic [FINE_W-1:0] split_fine_q;
  logic              last_b_q, ext_valid_q, split_valid_q;
  logic [EXT_W-1:0]  ext_bank_q;

  logic              use_b, ext_hit, split_hit;
  logic [OUT_W-1:0]  norm_addr, ext_addr, split_addr, next_addr;

  chr_bank_regs #(
    .DATA_W(DATA_W), .HI_W(HI_W), .NUM_A(NUM_A), .NUM_B(NUM_B),
    .TILE_W(TILE_W), .FINE_W(FINE_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_load(ext_load), .ext_tile_bank(ext_tile_bank),
    .bank_q(bank_q), .mode_q(mode_q), .upper_q(upper_q),
    .split_bank_q(split_bank_q), .split_fine_q(split_fine_q),
    .last_b_q(last_b_q), .ext_valid_q(ext_valid_q), .ext_bank_q(ext_bank_q),
    .split_valid_q(split_valid_q)
  );

  assign use_b = tall_sprites ? !fetch_sprite : last_b_q;

  chr_addr_map #(
    .FETCH_W(FETCH_W), .BANK_W(BANK_W), .NUM_A(NUM_A), .NUM_B(NUM_B)
  ) u_map (
    .mode(mode_q), .use_b(use_b), .addr(fetch_addr), .bank(bank_q),
    .lin_addr(norm_addr)
  );

  always_comb begin
    ext_hit    = !fetch_sprite && ext_attr_en && ext_valid_q;
    split_hit  = !fetch_sprite && split_active && split_valid_q;
    ext_addr   = OUT_W'({ext_bank_q, fetch_addr[FETCH_W-2:0]});
    split_addr = OUT_W'({split_bank_q, 2'b00, fetch_addr[9:3], split_fine_q});
    if (ext_hit)
      next_addr = ext_addr;
    else if (split_hit)
      next_addr = split_addr;
    else
      next_addr = norm_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= fetch_req;
      if (fetch_req)
        out_addr <= next_addr;
    end
  end

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> out_valid);

  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_req |=> !out_valid);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_req |=> $stable(out_addr));
endmodule

// File: tb/chr_bank_resolver_test.sv
module chr_bank_resolver_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, ext_load = 0, ext_attr_en = 0, split_active = 0;
  logic        tall_sprites = 0, fetch_req = 0, fetch_sprite = 0;
  logic [3:0]  wr_sel = 0;
  logic [7:0]  wr_data = 0;
  logic [5:0]  ext_tile_bank = 0;
  logic [12:0] fetch_addr = 0;
  logic        out_valid;
  logic [22:0] out_addr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state
  int bank_m [12];
  int mode_m = 3, upper_m = 0, sbank_m = 0, sfine_m = 0;
  bit last_b_m = 0, extv_m = 0, splv_m = 0;
  int extbank_m = 0;
  bit exp_v = 0;
  logic [22:0] exp_a = 0;

  always #10 clk = ~clk;

  chr_bank_resolver uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_load(ext_load), .ext_tile_bank(ext_tile_bank), .ext_attr_en(ext_attr_en),
    .split_active(split_active), .tall_sprites(tall_sprites), .fetch_req(fetch_req),
    .fetch_sprite(fetch_sprite), .fetch_addr(fetch_addr),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic int ref_addr(int a, bit spr);
    int slot, idx, size, off;
    bit b;
    if (!spr && ext_attr_en && extv_m) return extbank_m * 4096 + (a & 'hFFF);
    if (!spr && split_active && splv_m) return sbank_m * 4096 + (a & 'h3F8) + sfine_m;
    b = tall_sprites ? !spr : last_b_m;
    slot = a / 1024;
    if (mode_m == 0) idx = 7;
    else if (mode_m == 1) idx = slot | 3;
    else if (mode_m == 2) idx = slot | 1;
    else idx = slot;
    if (b) idx = 8 + (idx % 4);
    size = 8192 / (1 << mode_m);
    off = a % size;
    if (b && mode_m == 0) off = a % 4096;
    return bank_m[idx] * size + off;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic step(input bit dw, input int ds, input int dd, input bit df, input int fa,
                      input bit fs, input bit dx, input int xb, input string tag);
    bit clr;
    wr_en = dw; wr_sel = 4'(ds); wr_data = 8'(dd);
    fetch_req = df; fetch_addr = 13'(fa); fetch_sprite = fs;
    ext_load = dx; ext_tile_bank = 6'(xb);
    exp_v = df;
    if (df) exp_a = 23'(ref_addr(fa, fs));
    clr = dw && ds <= 13;
    if (dx && !clr) begin extv_m = 1; extbank_m = xb + upper_m * 64; end
    if (clr) begin extv_m = 0; splv_m = 0; end
    if (dw) begin
      if (ds < 12) begin bank_m[ds] = dd + upper_m * 256; last_b_m = (ds >= 8); end
      else if (ds == 12) mode_m = dd % 4;
      else if (ds == 13) upper_m = dd % 4;
      else if (ds == 14) begin sbank_m = dd; splv_m = 1; end
      else sfine_m = dd % 8;
    end
    @(posedge clk);
    @(negedge clk);
    compared++;
    if (out_valid !== exp_v || out_addr !== exp_a) begin
      mismatched++;
      $display("FAIL %s: actual valid=%0b addr=%06h expected valid=%0b addr=%06h",
               tag, out_valid, out_addr, exp_v, exp_a);
    end
  endtask

  task automatic wr(input int s, input int d, input string tag);
    step(1, s, d, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fetch(input int a, input bit spr, input string tag);
    step(0, 0, 0, 1, a, spr, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) bank_m[i] = 'h3FF;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state at the ports
    compared++;
    if (out_valid !== 1'b0 || out_addr !== 23'h0) begin
      mismatched++;
      $display("FAIL R1 reset: actual valid=%0b addr=%06h expected 0/0", out_valid, out_addr);
    end
    fetch('h1234, 0, "R1 reset banks");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle hold");
    // R3 load set A then set B with mixed upper values
    for (int i = 0; i < 8; i++) wr(i, 'h10 + i * 3, "R3 write A");
    wr(13, 2, "R3 upper");
    wr(5, 'h44, "R3 write A upper");
    for (int i = 8; i < 12; i++) wr(i, 'h80 + i, "R3 write B");
    wr(13, 1, "R3 upper");
    wr(0, 'hC1, "R7 set A latest");
    // R4 all modes, all slots, set A
    for (int m = 0; m < 4; m++) begin
      wr(12, m, "R4 mode");
      for (int s = 0; s < 8; s++) fetch(s * 1024 + 'h2A5 + m, s[0], "R4 set A");
    end
    // R5 / R7 set B latest
    wr(10, 'h5B, "R7 set B latest");
    for (int m = 0; m < 4; m++) begin
      wr(12, m, "R5 mode");
      for (int s = 0; s < 8; s++) fetch(s * 1024 + 'h1F7, 0, "R5 set B");
    end
    // R6 tall sprites
    tall_sprites = 1;
    wr(3, 'h22, "R6 A write");
    wr(12, 3, "R6 mode");
    for (int s = 0; s < 8; s++) begin
      fetch(s * 1024 + 'h0C, 1, "R6 sprite A");
      fetch(s * 1024 + 'h0C, 0, "R6 bg B");
    end
    tall_sprites = 0;
    // R8 extended override
    ext_attr_en = 1;
    step(0, 0, 0, 0, 0, 0, 1, 'h2D, "R8 load");
    fetch('h1ABC, 0, "R8 ext bg");
    fetch('h0ABC, 1, "R11 sprite not overridden");
    // R9 split override
    ext_attr_en = 0;
    split_active = 1;
    wr(15, 5, "R9 fine");
    fetch('h0777, 0, "R9 split not yet valid");
    wr(14, 'h9E, "R9 split bank");
    fetch('h0777, 0, "R9 split bg");
    fetch('h13FF, 0, "R9 split bg 2");
    fetch('h0777, 1, "R11 sprite not split");
    // R11 ext wins over split
    ext_attr_en = 1;
    fetch('h0321, 0, "R11 ext over split");
    // R10 clearing writes
    wr(12, 2, "R10 mode write");
    fetch('h0321, 0, "R10 flags cleared");
    wr(14, 'h31, "R10 split set");
    step(1, 13, 3, 0, 0, 0, 1, 'h11, "R10 clear beats load");
    fetch('h0456, 0, "R10 no ext after clear");
    wr(14, 'h32, "R10 split set");
    step(0, 0, 0, 0, 0, 0, 1, 'h3F, "R8 load");
    fetch('h0456, 0, "R8 ext with upper");
    wr(9, 'h77, "R10 bank write");
    fetch('h0456, 0, "R10 bank write clears");
    ext_attr_en = 0;
    split_active = 0;
    // R12 fetch concurrent with write
    step(1, 9, 'h12, 1, 'h0456, 0, 0, 0, "R12 old value");
    fetch('h0456, 0, "R12 new value");
    step(1, 12, 0, 1, 'h1456, 0, 0, 0, "R12 old mode");
    fetch('h1456, 0, "R12 new mode");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle hold");
    // R1 reset again mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 12; i++) bank_m[i] = 'h3FF;
    mode_m = 3; upper_m = 0; sbank_m = 0; sfine_m = 0;
    last_b_m = 0; extv_m = 0; splv_m = 0; extbank_m = 0; exp_a = 0;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1 reset outputs");
    fetch('h0FFF, 1, "R1 reset banks again");
    done = 1;
    summary();
    $finish;
  end
endmodule